// File: doc/BRIEF.md
# Bidirectional Column Sampling Strobe Controller

This block is the digital sampling front end of a display column driver. A single start token walks a chain of stage positions. Each position owns three column latches, one in each of the column groups A, B and C. Three phase enables, each one cycle long on the system clock, step the token. Phase 1 moves the token to the next position and strobes one group. Phase 2 and phase 3 strobe the other two groups at the same position. A direction input sets whether the token walks up from the low end or down from the high end. It also sets which of the two bidirectional start ports is the input and which one drives the cascade output to the next device.

Three sample inputs reach the three groups either straight or through a one-step rotation. Samples are written into one of two storage banks. The other bank drives the column outputs through registers. A rising edge on the output enable exchanges the roles of the two banks. After the last column of a line has been strobed, the block ignores the phase enables until a new start token arrives. The only exception is the single phase-1 step that passes the token out through the cascade port.

Top module: `column_sampler`

## Requirements
- R1: After a synchronous reset the block is idle, bank 0 is the write bank, every column output is zero and the cascade output is low. An output-enable swap made before any sample has been written shows all-zero columns.
- R2: With `dir` high, the start input is `port_r`. A phase-1 enable with the start input high loads the token at position 1 and strobes group A there. Phase 2 then strobes B and phase 3 strobes C. Each later phase 1 moves the token up one position. The strobe order is therefore A1, B1, C1, A2 … C80.
- R3: With `dir` low, the start input is `port_l`. The token loads at position 80. Phase 1 strobes group C, phase 2 strobes B and phase 3 strobes A. Each later phase 1 moves the token down one position. The strobe order is therefore C80, B80, A80, C79 … A1.
- R4: With `rot` low, `va`, `vb` and `vc` are written into groups A, B and C. With `rot` high, `va` goes to B, `vb` goes to C and `vc` goes to A.
- R5: When several phase enables are high in one cycle, only phase 1 acts if it is high. Otherwise only phase 2 acts. A phase enable that does not match the next expected step is ignored.
- R6: Each rising edge of `oe` exchanges the write bank and the display bank. Holding `oe` high makes no further exchange. The columns then show the line that was just written.
- R7: The cascade port (`port_l` when `dir` is high, `port_r` when it is low) goes high on the phase-1 step that follows the final strobe of a line. It returns low on the next phase-1 step.
- R8: Once a line is complete, phase enables without a start token write nothing. Column data written before the halt is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| dir | input | 1 | Walk direction: 1 = up from position 1, 0 = down from position 80 |
| port_r | inout | 1 | Start input when `dir`=1, cascade output when `dir`=0 |
| port_l | inout | 1 | Start input when `dir`=0, cascade output when `dir`=1 |
| ph1 | input | 1 | Phase-1 step enable |
| ph2 | input | 1 | Phase-2 step enable |
| ph3 | input | 1 | Phase-3 step enable |
| rot | input | 1 | Lane rotation select |
| va | input | 8 | Sample lane a |
| vb | input | 8 | Sample lane b |
| vc | input | 8 | Sample lane c |
| oe | input | 1 | Output enable; a rising edge swaps the banks |
| col_a | output | 640 | Group A columns, position k at bits [8(k-1) +: 8] |
| col_b | output | 640 | Group B columns, same layout |
| col_c | output | 640 | Group C columns, same layout |

## Verification
The group-selection properties assume that `dir` stays constant from a start token to the end of its line. The bench changes direction only between lines, so the checks tied to direction compare against the direction the token was loaded with. The bank-swap property assumes `oe` is a level input sampled on the clock. The stimulus raises it, holds it for several cycles and only then lowers it. Phase enables come as one-cycle pulses separated by an idle cycle. In one line every phase-1 pulse also raises phase 2 and phase 3, and every phase-2 pulse also raises phase 3, to exercise the priority rule.

// File: rtl/colsamp_pkg.sv
package colsamp_pkg;

  localparam int GROUPS = 3;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_WAIT2,
    SQ_WAIT3,
    SQ_WAIT1,
    SQ_LAST
  } seq_state_t;

  // group strobed by a phase (1..3) for a given walk direction
  function automatic logic [1:0] phase_group(input logic [1:0] ph, input logic up);
    logic [1:0] g;
    case (ph)
      2'd1:    g = up ? 2'd0 : 2'd2;
      2'd2:    g = 2'd1;
      default: g = up ? 2'd2 : 2'd0;
    endcase
    return g;
  endfunction

  // input lane feeding a group under the rotation select
  function automatic logic [1:0] src_lane(input logic [1:0] grp, input logic rot);
    logic [1:0] s;
    if (!rot)            s = grp;
    else if (grp == 2'd0) s = 2'd2;
    else                 s = grp - 2'd1;
    return s;
  endfunction

endpackage

// File: rtl/strobe_seq.sv
module strobe_seq
  import colsamp_pkg::*;
#(
  parameter int STAGES = 80,
  localparam int IW = $clog2(STAGES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ph1,
  input  logic          ph2,
  input  logic          ph3,
  input  logic          start_in,
  input  logic          up_in,
  output logic          wr_en,
  output logic [1:0]    wr_grp,
  output logic [IW-1:0] wr_idx,
  output logic          casc_q,
  output logic          busy
);

  localparam logic [IW-1:0] TOP_IDX = IW'(STAGES - 1);

  seq_state_t    st_q, st_d;
  logic [IW-1:0] idx_q, idx_d;
  logic          up_q, up_d;
  logic          p1, p2, p3;
  logic [IW-1:0] end_idx;

  assign end_idx = up_q ? TOP_IDX : '0;

  always_comb begin
    p1 = ph1;
    p2 = ph2 && !ph1;
    p3 = ph3 && !ph1 && !ph2;
    st_d   = st_q;
    idx_d  = idx_q;
    up_d   = up_q;
    wr_en  = 1'b0;
    wr_grp = 2'd0;
    if (p1 && start_in) begin
      up_d   = up_in;
      idx_d  = up_in ? '0 : TOP_IDX;
      st_d   = SQ_WAIT2;
      wr_en  = 1'b1;
      wr_grp = phase_group(2'd1, up_in);
    end else if (p1 && st_q == SQ_WAIT1) begin
      idx_d  = up_q ? idx_q + IW'(1) : idx_q - IW'(1);
      st_d   = SQ_WAIT2;
      wr_en  = 1'b1;
      wr_grp = phase_group(2'd1, up_q);
    end else if (p1 && st_q == SQ_LAST) begin
      st_d = SQ_IDLE;
    end else if (p2 && st_q == SQ_WAIT2) begin
      st_d   = SQ_WAIT3;
      wr_en  = 1'b1;
      wr_grp = phase_group(2'd2, up_q);
    end else if (p3 && st_q == SQ_WAIT3) begin
      st_d   = (idx_q == end_idx) ? SQ_LAST : SQ_WAIT1;
      wr_en  = 1'b1;
      wr_grp = phase_group(2'd3, up_q);
    end
  end

  assign wr_idx = idx_d;
  assign busy   = (st_q != SQ_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= SQ_IDLE;
      idx_q  <= '0;
      up_q   <= 1'b1;
      casc_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
      up_q  <= up_d;
      if (p1) casc_q <= (st_q == SQ_LAST);
    end
  end

endmodule

// File: rtl/lane_rotate.sv
module lane_rotate
  import colsamp_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          rot,
  input  logic [DW-1:0] va,
  input  logic [DW-1:0] vb,
  input  logic [DW-1:0] vc,
  output logic [DW-1:0] lane_o [GROUPS]
);

  logic [DW-1:0] src [GROUPS];

  assign src[0] = va;
  assign src[1] = vb;
  assign src[2] = vc;

  for (genvar g = 0; g < GROUPS; g++) begin : g_lane
    assign lane_o[g] = src[src_lane(2'(g), rot)];
  end

endmodule

// File: rtl/pingpong_store.sv
module pingpong_store
  import colsamp_pkg::*;
#(
  parameter int STAGES = 80,
  parameter int DW = 8,
  localparam int IW = $clog2(STAGES),
  localparam int FW = GROUPS * STAGES * DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [1:0]    wr_grp,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] lane_i [GROUPS],
  input  logic          swap,
  output logic          wr_bank,
  output logic [FW-1:0] disp_flat
);

  logic [DW-1:0] mem_q  [2][GROUPS][STAGES];
  logic [DW-1:0] disp_q [GROUPS][STAGES];
  logic          bank_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int b = 0; b < 2; b++)
        for (int g = 0; g < GROUPS; g++)
          for (int k = 0; k < STAGES; k++)
            mem_q[b][g][k] <= '0;
    end else if (wr_en && wr_grp < 2'(GROUPS)) begin
      mem_q[bank_q][wr_grp][wr_idx] <= lane_i[wr_grp];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bank_q <= 1'b0;
    else if (swap) bank_q <= !bank_q;
  end

  always_ff @(posedge clk) begin
    for (int g = 0; g < GROUPS; g++)
      for (int k = 0; k < STAGES; k++)
        disp_q[g][k] <= rst ? '0 : mem_q[!bank_q][g][k];
  end

  assign wr_bank = bank_q;

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    for (genvar k = 0; k < STAGES; k++) begin : g_col
      assign disp_flat[(g*STAGES + k)*DW +: DW] = disp_q[g][k];
    end
  end

endmodule

// File: rtl/column_sampler.sv
module column_sampler
  import colsamp_pkg::*;
#(
  parameter int STAGES = 80,
  parameter int DW = 8,
  localparam int IW = $clog2(STAGES),
  localparam int CW = STAGES * DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dir,
  inout  wire           port_r,
  inout  wire           port_l,
  input  logic          ph1,
  input  logic          ph2,
  input  logic          ph3,
  input  logic          rot,
  input  logic [DW-1:0] va,
  input  logic [DW-1:0] vb,
  input  logic [DW-1:0] vc,
  input  logic          oe,
  output logic [CW-1:0] col_a,
  output logic [CW-1:0] col_b,
  output logic [CW-1:0] col_c
);

  logic          start_w;
  logic          casc_w;
  logic          busy_w;
  logic          wr_en_w;
  logic [1:0]    wr_grp_w;
  logic [IW-1:0] wr_idx_w;
  logic [DW-1:0] lane_w [GROUPS];
  logic          oe_q;
  logic          swap_w;
  logic          bank_w;
  logic [GROUPS*CW-1:0] disp_w;

  assign start_w = dir ? port_r : port_l;
  assign port_l  = dir ? casc_w : 1'bz;
  assign port_r  = dir ? 1'bz : casc_w;

  always_ff @(posedge clk) begin
    if (rst) oe_q <= 1'b0;
    else     oe_q <= oe;
  end
  assign swap_w = oe && !oe_q;

  strobe_seq #(.STAGES(STAGES)) u_seq (
    .clk(clk), .rst(rst), .ph1(ph1), .ph2(ph2), .ph3(ph3),
    .start_in(start_w), .up_in(dir),
    .wr_en(wr_en_w), .wr_grp(wr_grp_w), .wr_idx(wr_idx_w),
    .casc_q(casc_w), .busy(busy_w)
  );

  lane_rotate #(.DW(DW)) u_rot (
    .rot(rot), .va(va), .vb(vb), .vc(vc), .lane_o(lane_w)
  );

  pingpong_store #(.STAGES(STAGES), .DW(DW)) u_store (
    .clk(clk), .rst(rst), .wr_en(wr_en_w), .wr_grp(wr_grp_w),
    .wr_idx(wr_idx_w), .lane_i(lane_w), .swap(swap_w),
    .wr_bank(bank_w), .disp_flat(disp_w)
  );

  assign col_a = disp_w[0*CW +: CW];
  assign col_b = disp_w[1*CW +: CW];
  assign col_c = disp_w[2*CW +: CW];

endmodule

// File: rtl/column_sampler_chk.sv
module column_sampler_chk (
  input logic       clk,
  input logic       rst,
  input logic       dir,
  input logic       ph1,
  input logic       ph2,
  input logic       oe,
  input logic       start_in,
  input logic       casc,
  input logic       busy,
  input logic       wr_en,
  input logic [1:0] wr_grp,
  input logic       wr_bank
);

  assert_reset_state_R1: assert property (@(posedge clk)
    $past(rst) |-> (!wr_bank && !casc && !busy));

  assert_fwd_phase1_group_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && ph1 && dir) |-> (wr_grp == 2'd0));

  assert_rev_phase1_group_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && ph1 && !dir) |-> (wr_grp == 2'd2));

  assert_phase2_group_b_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && ph2 && !ph1) |-> (wr_grp == 2'd1));

  assert_swap_needs_oe_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_bank != $past(wr_bank)) |-> $past(oe));

  assert_casc_on_phase1_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(casc) |-> $past(ph1));

  assert_no_write_when_idle_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !busy) |-> (ph1 && start_in));

endmodule

bind column_sampler column_sampler_chk u_chk (
  .clk(clk), .rst(rst), .dir(dir), .ph1(ph1), .ph2(ph2), .oe(oe),
  .start_in(start_w), .casc(casc_w), .busy(busy_w),
  .wr_en(wr_en_w), .wr_grp(wr_grp_w), .wr_bank(bank_w)
);

// File: tb/sim_column_sampler.sv
module sim_column_sampler;

  localparam int STAGES = 80;
  localparam int DW = 8;
  localparam int CW = STAGES * DW;
  localparam int NVEC = 6;
  // {dir, rot, seed}
  localparam logic [9:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 8'h11}, {1'b0, 1'b0, 8'h37}, {1'b1, 1'b1, 8'hC4},
    {1'b0, 1'b1, 8'h09}, {1'b1, 1'b0, 8'hEE}, {1'b0, 1'b1, 8'h72}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dir = 1'b1, rot = 1'b0, oe = 1'b0;
  logic ph1 = 1'b0, ph2 = 1'b0, ph3 = 1'b0;
  logic start_tb = 1'b0;
  logic [DW-1:0] va = '0, vb = '0, vc = '0;
  logic [CW-1:0] col_a, col_b, col_c;
  wire port_r, port_l;
  int checks = 0;
  int errors = 0;

  assign port_r = dir ? start_tb : 1'bz;
  assign port_l = dir ? 1'bz : start_tb;

  always #10 clk = ~clk;

  column_sampler #(.STAGES(STAGES), .DW(DW)) u0 (
    .clk(clk), .rst(rst), .dir(dir), .port_r(port_r), .port_l(port_l),
    .ph1(ph1), .ph2(ph2), .ph3(ph3), .rot(rot),
    .va(va), .vb(vb), .vc(vc), .oe(oe),
    .col_a(col_a), .col_b(col_b), .col_c(col_c)
  );

  function automatic logic [7:0] smp(input logic [7:0] seed, input int s, input int p, input int i);
    return 8'(int'(seed) + s*5 + p*3 + i*11);
  endfunction

  function automatic logic [7:0] col_val(input int g, input int k);
    logic [CW-1:0] v;
    v = (g == 0) ? col_a : (g == 1) ? col_b : col_c;
    return v[k*DW +: DW];
  endfunction

  task automatic check_bit(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  // every column of group g against a line written with (d, r, seed)
  task automatic check_group(input string req, input int g, input logic d, input logic r,
                             input logic [7:0] seed, input logic zero);
    int bad = 0;
    logic [7:0] fa = '0, fe = '0;
    int fk = 0;
    for (int k = 0; k < STAGES; k++) begin
      int s, p, ln;
      logic [7:0] e;
      s  = d ? k : STAGES - 1 - k;
      p  = d ? g + 1 : 3 - g;
      ln = r ? (g + 2) % 3 : g;
      e  = zero ? 8'h00 : smp(seed, s, p, ln);
      if (col_val(g, k) !== e) begin
        if (bad == 0) begin fa = col_val(g, k); fe = e; fk = k; end
        bad++;
      end
    end
    checks++;
    if (bad != 0) begin
      errors++;
      $display("FAIL %s: group %0d column %0d actual %02h expected %02h (%0d bad)",
               req, g, fk + 1, fa, fe, bad);
    end
  endtask

  task automatic pulse(input logic a, input logic b, input logic c, input logic st);
    @(negedge clk);
    ph1 = a; ph2 = b; ph3 = c; start_tb = st;
    @(negedge clk);
    ph1 = 1'b0; ph2 = 1'b0; ph3 = 1'b0; start_tb = 1'b0;
  endtask

  task automatic swap_banks();
    @(negedge clk); oe = 1'b1;
    repeat (4) @(negedge clk);
    oe = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic run_line(input logic d, input logic r, input logic [7:0] seed, input logic crowd);
    @(negedge clk); dir = d; rot = r;
    for (int s = 0; s < STAGES; s++) begin
      for (int p = 1; p <= 3; p++) begin
        va = smp(seed, s, p, 0);
        vb = smp(seed, s, p, 1);
        vc = smp(seed, s, p, 2);
        if (p == 1)      pulse(1'b1, crowd, crowd, s == 0);
        else if (p == 2) pulse(1'b0, 1'b1, crowd, 1'b0);
        else             pulse(1'b0, 1'b0, 1'b1, 1'b0);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    for (int g = 0; g < 3; g++) check_group("R1 reset columns", g, 1'b1, 1'b0, 8'h00, 1'b1);
    check_bit("R1 cascade low", port_l, 1'b0);
    swap_banks();
    for (int g = 0; g < 3; g++) check_group("R1 swap after reset", g, 1'b1, 1'b0, 8'h00, 1'b1);

    // table walk: R2/R3 order, R4 rotation, R6 swap, R7 cascade, R8 halt
    for (int v = 0; v < NVEC; v++) begin
      logic d, r;
      logic [7:0] seed;
      d = VEC[v][9]; r = VEC[v][8]; seed = VEC[v][7:0];
      run_line(d, r, seed, 1'b0);
      va = 8'hA5; vb = 8'h5A; vc = 8'hFF;
      pulse(1'b1, 1'b0, 1'b0, 1'b0);
      check_bit("R7 cascade high after last", d ? port_l : port_r, 1'b1);
      pulse(1'b0, 1'b1, 1'b0, 1'b0);
      pulse(1'b0, 1'b0, 1'b1, 1'b0);
      pulse(1'b1, 1'b0, 1'b0, 1'b0);
      check_bit("R7 cascade low next phase1", d ? port_l : port_r, 1'b0);
      pulse(1'b0, 1'b1, 1'b0, 1'b0);
      pulse(1'b0, 1'b0, 1'b1, 1'b0);
      swap_banks();
      for (int g = 0; g < 3; g++)
        check_group(d ? (r ? "R2 R4 R6 R8 fwd rot" : "R2 R4 R6 R8 fwd")
                      : (r ? "R3 R4 R6 R8 rev rot" : "R3 R4 R6 R8 rev"),
                    g, d, r, seed, 1'b0);
    end

    // R5: crowded phase enables, priority must leave a normal line
    run_line(1'b1, 1'b1, 8'h5A, 1'b1);
    pulse(1'b1, 1'b0, 1'b0, 1'b0);
    swap_banks();
    for (int g = 0; g < 3; g++) check_group("R5 phase priority", g, 1'b1, 1'b1, 8'h5A, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule